// File: doc/BRIEF.md
# Programmable Multiplex Row Scan Sequencer

This block walks a multiplexed LCD through its rows and produces the timing strobes that the column logic needs. The scan length is chosen by a two-bit multiplex code (8, 16, 20 or 24 rows). An optional icon line adds one row. The scan can run from the first row upward or from the last row downward. A frame polarity bit flips at every frame wrap and is used for AC drive inversion.

In row-drive mode the sequencer advances once per row-rate clock enable and drives its frame polarity out on the frame pin. In column-only mode it asserts no row outputs and ignores the row-rate enable. It then advances once per rising edge of an external frame input, which it synchronizes to its own clock. Two sleep controls force every output low and hold the scan at its start point.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `row_scan_seq`

## Requirements
- R1: While reset is asserted and in the first cycles after it is released, row_idx is 0 and row_strobe, frame_pol and frame_out are 0.
- R2: mux_sel selects the base row count N: 0→8, 1→16, 2→20, 3→24. Rows are numbered 0..N-1 on row_idx. While awake in row-drive mode, row_onehot has exactly one bit set, and that bit is at position row_idx.
- R3: With icon_en=1 the row count is the base count plus one, giving 9, 17, 21 or 25.
- R4: With row_rev=0 the index steps 0,1,…,N-1 and wraps to 0. With row_rev=1 it steps N-1,…,0 and wraps to N-1.
- R5: In row-drive mode, each clock cycle with row_tick=1 advances the index by one step. row_strobe is high for exactly the one cycle after the tick edge, and that is the cycle in which the new index first appears.
- R6: frame_pol toggles on every step that wraps the index. frame_out equals frame_pol in row-drive mode.
- R7: A change of mux_sel, icon_en or row_rev takes effect only at the next wrap. The index then restarts at the first row of the new setting.
- R8: With row_drv_en=0, row_onehot and frame_out stay 0 and row_tick is ignored. The index advances once per rising edge of ext_frame, counted after the synchronizer.
- R9: While sleep or sleep2 is 1, all outputs are 0 and scanning stops. After waking, the index starts at the first row of the current setting and frame_pol is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_tick | input | 1 | Row-rate enable: one step per cycle high (row-drive mode) |
| mux_sel | input | 2 | Multiplex code: 0→8, 1→16, 2→20, 3→24 rows |
| icon_en | input | 1 | Adds one icon row to the scan |
| row_rev | input | 1 | 1 = scan from the last row down |
| row_drv_en | input | 1 | 1 = row-drive mode with internal framing; 0 = column-only mode with external framing |
| ext_frame | input | 1 | External frame input, asynchronous |
| sleep | input | 1 | Sleep: outputs low, scan stopped |
| sleep2 | input | 1 | Second sleep control, same effect |
| row_onehot | output | MAX_ROWS | One-hot active row select |
| row_idx | output | IDX_W | Binary active row index |
| row_strobe | output | 1 | One-cycle pulse on each row step |
| frame_pol | output | 1 | Frame polarity, toggles at each wrap |
| frame_out | output | 1 | Frame signal driven out in row-drive mode |

## Verification
The bench sweeps all sixteen combinations of multiplex code, icon bit and direction. In each one it steps through more than two full frames and computes the expected index and polarity from the tick count. This sweep separates the four lengths from one another, shows whether the icon row was added, and tells the two wrap points apart. A mid-frame change of the multiplex code is checked against both the old and the new length, so applying it early or late gives a different index. Separate patterns drive row ticks and external frame pulses in column-only mode, and sleep with a configuration change, to tell which step source is in use and which start row is taken on wake.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [1:0] {
    MUX_A = 2'd0,
    MUX_B = 2'd1,
    MUX_C = 2'd2,
    MUX_D = 2'd3
  } mux_code_e;

  function automatic int scan_rows(input logic [1:0] code, input logic icon,
                                   input int r0, input int r1, input int r2, input int r3);
    int base;
    case (mux_code_e'(code))
      MUX_A:   base = r0;
      MUX_B:   base = r1;
      MUX_C:   base = r2;
      default: base = r3;
    endcase
    return base + (icon ? 1 : 0);
  endfunction

endpackage

// File: rtl/scan_cfg.sv
module scan_cfg #(
  parameter int ROWS_M0 = 8,
  parameter int ROWS_M1 = 16,
  parameter int ROWS_M2 = 20,
  parameter int ROWS_M3 = 24,
  parameter int LEN_W   = 5,
  parameter int IDX_W   = 5
) (
  input  logic [1:0]       mux_sel,
  input  logic             icon_en,
  input  logic             row_rev,
  output logic [LEN_W-1:0] len_o,
  output logic [IDX_W-1:0] first_o
);
  import row_scan_pkg::*;

  always_comb begin
    len_o   = LEN_W'(scan_rows(mux_sel, icon_en, ROWS_M0, ROWS_M1, ROWS_M2, ROWS_M3));
    first_o = row_rev ? IDX_W'(len_o - LEN_W'(1)) : '0;
  end

endmodule

// File: rtl/frame_edge.sv
module frame_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [SYNC_STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain_q[g] <= 1'b0;
        end else if (g == 0) begin
          chain_q[g] <= async_in;
        end else begin
          chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/row_counter.sv
module row_counter #(
  parameter int LEN_W = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             asleep,
  input  logic             step,
  input  logic [LEN_W-1:0] len_in,
  input  logic [IDX_W-1:0] first_in,
  input  logic             rev_in,
  output logic [IDX_W-1:0] idx_q,
  output logic             pol_q,
  output logic             strobe_q
);
  logic [LEN_W-1:0] len_q;
  logic             rev_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = rev_q ? '0 : IDX_W'(len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= LEN_W'(8);
      rev_q    <= 1'b0;
      idx_q    <= '0;
      pol_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else if (asleep) begin
      len_q    <= len_in;
      rev_q    <= rev_in;
      idx_q    <= first_in;
      pol_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= step;
      if (step) begin
        if (idx_q == last_idx) begin
          len_q <= len_in;
          rev_q <= rev_in;
          idx_q <= first_in;
          pol_q <= ~pol_q;
        end else if (rev_q) begin
          idx_q <= idx_q - IDX_W'(1);
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/row_decode.sv
module row_decode #(
  parameter int MAX_ROWS = 25,
  parameter int IDX_W    = 5
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic                en,
  output logic [MAX_ROWS-1:0] onehot
);
  genvar k;
  generate
    for (k = 0; k < MAX_ROWS; k++) begin : g_row
      assign onehot[k] = en && (idx == IDX_W'(k));
    end
  endgenerate

endmodule

// File: rtl/row_scan_seq.sv
module row_scan_seq #(
  parameter int ROWS_M0     = 8,
  parameter int ROWS_M1     = 16,
  parameter int ROWS_M2     = 20,
  parameter int ROWS_M3     = 24,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_ROWS   = ROWS_M3 + 1,
  localparam int IDX_W      = $clog2(MAX_ROWS),
  localparam int LEN_W      = $clog2(MAX_ROWS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_tick,
  input  logic [1:0]          mux_sel,
  input  logic                icon_en,
  input  logic                row_rev,
  input  logic                row_drv_en,
  input  logic                ext_frame,
  input  logic                sleep,
  input  logic                sleep2,
  output logic [MAX_ROWS-1:0] row_onehot,
  output logic [IDX_W-1:0]    row_idx,
  output logic                row_strobe,
  output logic                frame_pol,
  output logic                frame_out
);
  logic             asleep;
  logic             ext_rise;
  logic             step;
  logic [LEN_W-1:0] len_w;
  logic [IDX_W-1:0] first_w;
  logic [IDX_W-1:0] idx_q;
  logic             pol_q;
  logic             strobe_q;

  assign asleep = sleep | sleep2;

  scan_cfg #(
    .ROWS_M0(ROWS_M0), .ROWS_M1(ROWS_M1), .ROWS_M2(ROWS_M2), .ROWS_M3(ROWS_M3),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_cfg (
    .mux_sel (mux_sel),
    .icon_en (icon_en),
    .row_rev (row_rev),
    .len_o   (len_w),
    .first_o (first_w)
  );

  frame_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_frame),
    .rise_o   (ext_rise)
  );

  assign step = row_drv_en ? row_tick : ext_rise;

  row_counter #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .asleep   (asleep),
    .step     (step),
    .len_in   (len_w),
    .first_in (first_w),
    .rev_in   (row_rev),
    .idx_q    (idx_q),
    .pol_q    (pol_q),
    .strobe_q (strobe_q)
  );

  row_decode #(.MAX_ROWS(MAX_ROWS), .IDX_W(IDX_W)) u_dec (
    .idx    (idx_q),
    .en     (row_drv_en && !asleep),
    .onehot (row_onehot)
  );

  assign row_idx    = asleep ? '0 : idx_q;
  assign row_strobe = strobe_q & ~asleep;
  assign frame_pol  = pol_q & ~asleep;
  assign frame_out  = pol_q & row_drv_en & ~asleep;

endmodule

// File: rtl/row_scan_seq_chk.sv
module row_scan_seq_chk #(
  parameter int MAX_ROWS = 25,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                row_tick,
  input logic                row_drv_en,
  input logic                sleep,
  input logic                sleep2,
  input logic [MAX_ROWS-1:0] row_onehot,
  input logic [IDX_W-1:0]    row_idx,
  input logic                row_strobe,
  input logic                frame_pol,
  input logic                frame_out
);
  logic awake;
  assign awake = !sleep && !sleep2;

  AST_ONE_ROW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && row_drv_en) |-> ($countones(row_onehot) == 1 && row_onehot[row_idx])); // R2

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_idx) < MAX_ROWS); // R3

  AST_TICK_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && row_drv_en && row_tick) |=> (row_strobe || sleep || sleep2)); // R5

  AST_POL_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && $past(awake) && frame_pol != $past(frame_pol)) |-> row_strobe); // R6

  AST_COLONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !row_drv_en |-> (row_onehot == '0 && !frame_out)); // R8

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> (row_onehot == '0 && row_idx == '0 && !row_strobe && !frame_pol && !frame_out)); // R9

endmodule

bind row_scan_seq row_scan_seq_chk #(.MAX_ROWS(MAX_ROWS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_tick   (row_tick),
  .row_drv_en (row_drv_en),
  .sleep      (sleep),
  .sleep2     (sleep2),
  .row_onehot (row_onehot),
  .row_idx    (row_idx),
  .row_strobe (row_strobe),
  .frame_pol  (frame_pol),
  .frame_out  (frame_out)
);

// File: tb/row_scan_seq_tb.sv
module row_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 25;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_tick = 1'b0;
  logic [1:0] mux_sel = 2'd0;
  logic icon_en = 1'b0;
  logic row_rev = 1'b0;
  logic row_drv_en = 1'b1;
  logic ext_frame = 1'b0;
  logic sleep = 1'b0;
  logic sleep2 = 1'b0;
  logic [MAXR-1:0] row_onehot;
  logic [IW-1:0] row_idx;
  logic row_strobe, frame_pol, frame_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .mux_sel(mux_sel),
    .icon_en(icon_en), .row_rev(row_rev), .row_drv_en(row_drv_en),
    .ext_frame(ext_frame), .sleep(sleep), .sleep2(sleep2),
    .row_onehot(row_onehot), .row_idx(row_idx), .row_strobe(row_strobe),
    .frame_pol(frame_pol), .frame_out(frame_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) row_tick = 1'b1;
    @(negedge clk) row_tick = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_frame = 1'b1;
    repeat (4) @(negedge clk);
    ext_frame = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int rows_of(input int m, input int ic);
    int b;
    b = (m == 0) ? 8 : (m == 1) ? 16 : (m == 2) ? 20 : 24;
    return b + ic;
  endfunction

  task automatic setup(input int m, input int ic, input int rv);
    @(negedge clk) sleep = 1'b1;
    mux_sel = 2'(m); icon_en = ic[0]; row_rev = rv[0];
    @(negedge clk) sleep = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int nrows, e, ncnt;
    repeat (3) @(negedge clk);
    check("R1 idx in reset", int'(row_idx), 0);
    check("R1 pol in reset", int'(frame_pol), 0);
    check("R1 frame_out in reset", int'(frame_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idx after reset", int'(row_idx), 0);
    check("R1 strobe after reset", int'(row_strobe), 0);
    check("R1 onehot after reset", int'(row_onehot), 1);

    // R2 R3 R4 R5 R6: sweep every length, icon and direction
    for (int m = 0; m < 4; m++) begin
      for (int ic = 0; ic < 2; ic++) begin
        for (int rv = 0; rv < 2; rv++) begin
          setup(m, ic, rv);
          nrows = rows_of(m, ic);
          e = rv ? nrows - 1 : 0;
          check("R4 first row", int'(row_idx), e);
          check("R2 first onehot", int'(row_onehot[e]), 1);
          for (int k = 1; k <= 2*nrows + 1; k++) begin
            tick();
            e = rv ? nrows - 1 - (k % nrows) : (k % nrows);
            check("R3 R4 index", int'(row_idx), e);
            check("R2 onehot", int'(row_onehot[e]) + 10*$countones(row_onehot), 11);
            check("R5 strobe", int'(row_strobe), 1);
            check("R6 pol", int'(frame_pol), (k / nrows) % 2);
            check("R6 frame_out", int'(frame_out), (k / nrows) % 2);
          end
          @(negedge clk);
          check("R5 strobe single cycle", int'(row_strobe), 0);
        end
      end
    end

    // R7: mid-frame code change waits for the wrap
    setup(0, 0, 0);
    repeat (3) tick();
    mux_sel = 2'd3;
    tick();
    check("R7 no early apply", int'(row_idx), 4);
    repeat (3) tick();
    check("R7 old length end", int'(row_idx), 7);
    tick();
    check("R7 restart at wrap", int'(row_idx), 0);
    repeat (10) tick();
    check("R7 new length used", int'(row_idx), 10);

    // R9: sleep2 quiets outputs, wake restarts with new setting
    @(negedge clk) sleep2 = 1'b1;
    @(negedge clk);
    check("R9 idx asleep", int'(row_idx), 0);
    check("R9 onehot asleep", int'(row_onehot), 0);
    check("R9 pol asleep", int'(frame_pol) + int'(frame_out), 0);
    tick(); tick();
    check("R9 no step asleep", int'(row_strobe) + int'(row_idx), 0);
    mux_sel = 2'd1; icon_en = 1'b1; row_rev = 1'b1;
    @(negedge clk) sleep2 = 1'b0;
    @(negedge clk);
    check("R9 wake first row", int'(row_idx), 16);
    check("R9 wake pol", int'(frame_pol), 0);
    tick();
    check("R9 resumes scan", int'(row_idx), 15);

    // R8: column-only mode
    setup(0, 0, 0);
    row_drv_en = 1'b0;
    repeat (3) tick();
    check("R8 row_tick ignored", int'(row_idx), 0);
    check("R8 onehot zero", int'(row_onehot), 0);
    ncnt = 0;
    repeat (3) ext_pulse();
    check("R8 ext edges step", int'(row_idx), 3);
    repeat (5) ext_pulse();
    check("R8 ext wrap", int'(row_idx), 0);
    check("R8 pol toggled", int'(frame_pol), 1);
    check("R8 frame_out low", int'(frame_out), 0);
    check("R8 onehot still zero", int'(row_onehot), ncnt);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule